// File: doc/BRIEF.md
# Three-Wire Transceiver Configuration Sequencer

This block loads the register set of an external half-duplex IF transceiver through a three-wire serial link: a serial clock, a data line and a latch strobe. The host supplies four 18-bit register payloads as static inputs: the operating mode, the reference divider, the VCO divider and the DC-offset-correction setting. The block appends a 2-bit register address to each payload to form a 20-bit frame. It shifts the frame out, most significant bit first, and then pulses the latch. A start request sends all four frames, and the mode frame always goes first.

Once the mode frame has been delivered, a single non-mode register can be rewritten on its own through an update request. Two enable pins select receive or transmit together with bit 0 of the mode payload. These pins follow a host select input directly, so switching direction never touches the serial link. A busy level and a one-cycle done pulse tell the host when the link is in use.

Top module: `cfgseq_top`

## Requirements
- R1: Each frame carries exactly 20 bits, most significant bit first. Each bit is sampled on a rising edge of `ser_clk_o`, and `ser_dat_o` changes only while `ser_clk_o` is low.
- R2: Frame bits [1:0] hold the register address (mode = 00, reference divider = 01, VCO divider = 10, offset correction = 11). Bits [19:2] hold that register's 18-bit payload.
- R3: A start request sends the four frames in the order mode, reference divider, VCO divider, offset correction.
- R4: After the 20th rising edge, `ser_le_o` rises on the falling edge of the clock. It stays high for exactly one serial period (2*HALF_DIV system clocks) while `ser_clk_o` stays low. Clock and latch are both low whenever the block is not busy.
- R5: The next frame's first rising clock edge comes more than 2*HALF_DIV system clocks after the previous latch falls.
- R6: `busy_o` rises one cycle after an accepted request and falls when the last frame's idle gap ends. `done_o` is high for exactly one cycle, in the first cycle `busy_o` is low again.
- R7: A start or update request made while `busy_o` is high has no effect.
- R8: An update request with `upd_sel_i` set to 1, 2 or 3 sends exactly one frame, for that register address. This happens only if a mode frame has been latched since reset. An update request with select 0, or one made before any mode frame, is ignored.
- R9: `pe_rx_o` and `pe_tx_o` are both low until a mode frame has been latched. After that, `pe_rx_o` = not `tx_sel_i` and `pe_tx_o` = `tx_sel_i` AND bit 0 of the last latched mode payload. The pins take their new values one clock after `tx_sel_i` changes, and no serial activity is caused.
- R10: Asserting `rst_ni` low at once returns every output to idle and forgets that the mode frame was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send the full register set |
| upd_req_i | input | 1 | Request to resend one non-mode register |
| upd_sel_i | input | 2 | Register address for an update request |
| tx_sel_i | input | 1 | Host direction select, 1 = transmit |
| mode_pl_i | input | 18 | Mode register payload |
| ref_pl_i | input | 18 | Reference divider payload |
| vco_pl_i | input | 18 | VCO divider payload |
| dco_pl_i | input | 18 | Offset correction payload |
| ser_clk_o | output | 1 | Serial clock |
| ser_dat_o | output | 1 | Serial data |
| ser_le_o | output | 1 | Latch enable |
| pe_rx_o | output | 1 | Receive enable pin |
| pe_tx_o | output | 1 | Transmit enable pin |
| busy_o | output | 1 | Link in use |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong bit counter shows up within the first frame: the latch strobe rises after a number of clock edges other than twenty. A wrong register index shows up in the address field of the very next captured frame. A mode flag that is wrongly set or cleared shows up on the enable pins one clock after `tx_sel_i` moves, or as an update request that is wrongly sent or wrongly dropped. Errors in the phase counter change the measured latch width or the gap between frames within a single serial period.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int unsigned PAY_W   = 18;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned FRAME_W = PAY_W + ADDR_W;
  localparam int unsigned NREG    = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE = 2'd0,
    REG_REF  = 2'd1,
    REG_VCO  = 2'd2,
    REG_DCO  = 2'd3
  } cfg_reg_e;

  typedef enum logic [1:0] {SER_IDLE, SER_SHIFT, SER_LATCH, SER_GAP} ser_st_e;

  function automatic logic [FRAME_W-1:0] build_frame(logic [PAY_W-1:0] pl,
                                                     logic [ADDR_W-1:0] addr);
    return {pl, addr};
  endfunction
endpackage

// File: rtl/cfgseq_tick.sv
module cfgseq_tick #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/cfgseq_serializer.sv
module cfgseq_serializer
  import cfgseq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               idle_o,
  output logic               fin_o,
  output logic               sclk_o,
  output logic               sdat_o,
  output logic               sle_o
);
  localparam int unsigned BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  ser_st_e st_q, st_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [BW-1:0] bit_q, bit_d;
  logic ph_q, ph_d;
  logic sclk_q, sclk_d, le_q, le_d;

  always_comb begin
    st_d = st_q; sr_d = sr_q; bit_d = bit_q; ph_d = ph_q;
    sclk_d = sclk_q; le_d = le_q; fin_o = 1'b0;
    unique case (st_q)
      SER_IDLE: if (load_i) begin
        st_d = SER_SHIFT; sr_d = frame_i; bit_d = '0; ph_d = 1'b0;
      end
      SER_SHIFT: if (tick_i) begin
        if (!ph_q) begin
          sclk_d = 1'b1; ph_d = 1'b1;
        end else begin
          sclk_d = 1'b0; ph_d = 1'b0;
          if (bit_q == LAST_BIT) begin
            st_d = SER_LATCH; le_d = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
            sr_d  = {sr_q[FRAME_W-2:0], 1'b0};
          end
        end
      end
      SER_LATCH: if (tick_i) begin
        ph_d = ~ph_q;
        if (ph_q) begin
          le_d = 1'b0; st_d = SER_GAP;
        end
      end
      SER_GAP: if (tick_i) begin
        ph_d = ~ph_q;
        if (ph_q) begin
          st_d = SER_IDLE; fin_o = 1'b1;
        end
      end
      default: st_d = SER_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q <= SER_IDLE; sr_q <= '0; bit_q <= '0; ph_q <= 1'b0;
      sclk_q <= 1'b0; le_q <= 1'b0;
    end else begin
      st_q <= st_d; sr_q <= sr_d; bit_q <= bit_d; ph_q <= ph_d;
      sclk_q <= sclk_d; le_q <= le_d;
    end

  assign idle_o = (st_q == SER_IDLE);
  assign sclk_o = sclk_q;
  assign sdat_o = (st_q == SER_SHIFT) & sr_q[FRAME_W-1];
  assign sle_o  = le_q;
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
  import cfgseq_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             upd_req_i,
  input  logic [ADDR_W-1:0] upd_sel_i,
  input  logic             tx_sel_i,
  input  logic [PAY_W-1:0] mode_pl_i,
  input  logic [PAY_W-1:0] ref_pl_i,
  input  logic [PAY_W-1:0] vco_pl_i,
  input  logic [PAY_W-1:0] dco_pl_i,
  output logic             ser_clk_o,
  output logic             ser_dat_o,
  output logic             ser_le_o,
  output logic             pe_rx_o,
  output logic             pe_tx_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [1:0] rsync_q;
  logic rst_n;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  assign rst_n = rsync_q[1];

  logic [PAY_W-1:0] pl_tab [NREG];
  logic [PAY_W*NREG-1:0] pl_flat;
  assign pl_flat = {dco_pl_i, vco_pl_i, ref_pl_i, mode_pl_i};
  for (genvar g = 0; g < NREG; g++) begin : g_tab
    assign pl_tab[g] = pl_flat[g*PAY_W +: PAY_W];
  end

  logic tick, load, ser_idle, fin;
  logic busy_q, busy_d, pend_q, pend_d, one_q, one_d, done_q, done_d;
  logic mode_ok_q, mode_ok_d, mode_b0_q, mode_b0_d, rx_q, rx_d, tx_q, tx_d;
  cfg_reg_e idx_q, idx_d;

  cfgseq_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_o(tick));

  cfgseq_serializer u_ser (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .load_i(load),
    .frame_i(build_frame(pl_tab[idx_q], idx_q)),
    .idle_o(ser_idle), .fin_o(fin),
    .sclk_o(ser_clk_o), .sdat_o(ser_dat_o), .sle_o(ser_le_o));

  assign load = busy_q & pend_q & ser_idle;

  always_comb begin
    busy_d = busy_q; pend_d = pend_q; one_d = one_q; idx_d = idx_q;
    done_d = 1'b0; mode_ok_d = mode_ok_q; mode_b0_d = mode_b0_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1; pend_d = 1'b1; one_d = 1'b0; idx_d = REG_MODE;
      end else if (upd_req_i && mode_ok_q && (upd_sel_i != REG_MODE)) begin
        busy_d = 1'b1; pend_d = 1'b1; one_d = 1'b1; idx_d = cfg_reg_e'(upd_sel_i);
      end
    end else begin
      if (load) begin
        pend_d = 1'b0;
        if (idx_q == REG_MODE) mode_b0_d = pl_tab[REG_MODE][0];
      end
      if (fin) begin
        if (idx_q == REG_MODE) mode_ok_d = 1'b1;
        if (one_q || idx_q == REG_DCO) begin
          busy_d = 1'b0; done_d = 1'b1;
        end else begin
          idx_d = cfg_reg_e'(idx_q + 1'b1); pend_d = 1'b1;
        end
      end
    end
    rx_d = mode_ok_q & ~tx_sel_i;
    tx_d = mode_ok_q & tx_sel_i & mode_b0_q;
  end

  always_ff @(posedge clk_i or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; pend_q <= 1'b0; one_q <= 1'b0; idx_q <= REG_MODE;
      done_q <= 1'b0; mode_ok_q <= 1'b0; mode_b0_q <= 1'b0;
      rx_q <= 1'b0; tx_q <= 1'b0;
    end else begin
      busy_q <= busy_d; pend_q <= pend_d; one_q <= one_d; idx_q <= idx_d;
      done_q <= done_d; mode_ok_q <= mode_ok_d; mode_b0_q <= mode_b0_d;
      rx_q <= rx_d; tx_q <= tx_d;
    end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign pe_rx_o = rx_q;
  assign pe_tx_o = tx_q;
endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk,
  input logic sdat,
  input logic sle,
  input logic busy,
  input logic done,
  input logic pe_rx,
  input logic pe_tx,
  input logic mode_ok
);
  AST_LE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sle |-> !sclk); // R4
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk && $past(sclk)) |-> $stable(sdat)); // R1
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!sclk && !sle)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done); // R6
  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (!busy && $past(busy))); // R6
  AST_PIN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pe_rx && pe_tx)); // R9
  AST_NO_PINS_BEFORE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ok |-> (!pe_rx && !pe_tx)); // R9
endmodule

bind cfgseq_top cfgseq_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk(ser_clk_o), .sdat(ser_dat_o),
  .sle(ser_le_o), .busy(busy_o), .done(done_o), .pe_rx(pe_rx_o),
  .pe_tx(pe_tx_o), .mode_ok(mode_ok_q));

// File: tb/test_cfgseq_top.sv
`timescale 1ns/1ps
module test_cfgseq_top;
  localparam int HALF = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, upd = 0, txs = 0;
  logic [1:0] usel = 0;
  logic [17:0] mpl = 18'h2A5A5, rpl = 18'h00123, vpl = 18'h3F00F, dpl = 18'h15555;
  logic sclk, sdat, sle, perx, petx, busy, done;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  cfgseq_top #(.HALF_DIV(HALF)) i_cfgseq_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .upd_req_i(upd),
    .upd_sel_i(usel), .tx_sel_i(txs), .mode_pl_i(mpl), .ref_pl_i(rpl),
    .vco_pl_i(vpl), .dco_pl_i(dpl), .ser_clk_o(sclk), .ser_dat_o(sdat),
    .ser_le_o(sle), .pe_rx_o(perx), .pe_tx_o(petx), .busy_o(busy), .done_o(done));

  // Monitor of the serial link
  logic [19:0] log_q [16];
  logic [19:0] cap;
  int nlog = 0, nbits = 0, bits_bad = 0, le_bad = 0, stab_bad = 0;
  int le_w = 0, gap = 0, min_gap = 1000000;
  logic p_sclk = 0, p_sle = 0, p_sdat = 0, in_gap = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      nbits = 0; le_w = 0; in_gap = 0;
    end else begin
      if (sclk && p_sclk && sdat != p_sdat) stab_bad++;
      if (sclk && !p_sclk) begin
        cap = {cap[18:0], sdat}; nbits++;
        if (in_gap && gap < min_gap) min_gap = gap;
        in_gap = 0;
      end
      if (in_gap) gap++;
      if (sle) le_w++;
      if (sle && !p_sle) begin
        if (nbits != 20) bits_bad++;
        if (nlog < 16) log_q[nlog] = cap;
        nlog++; nbits = 0;
      end
      if (!sle && p_sle) begin
        if (le_w != 2*HALF) le_bad++;
        le_w = 0; in_gap = 1; gap = 1;
      end
    end
    p_sclk = sclk; p_sle = sle; p_sdat = sdat;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_done(output int dcnt);
    dcnt = 0;
    for (int i = 0; i < 4000; i++) begin
      step(1);
      if (done) dcnt++;
      if (!busy && dcnt > 0) break;
    end
    step(1);
    if (done) dcnt++;
  endtask

  task automatic t_reset();
    chk(!sclk && !sle && !busy && !done, "R10 idle lines", {sclk, sle, busy, done}, 0);
    chk(!perx && !petx, "R9 pins before mode", {perx, petx}, 0);
  endtask

  task automatic t_upd_early();
    int n0 = nlog;
    usel = 2'd1; upd = 1; step(1); upd = 0;
    chk(!busy, "R8 update before mode busy", busy, 0);
    step(300);
    chk(nlog == n0, "R8 update before mode frames", nlog - n0, 0);
  endtask

  task automatic t_full();
    int n0 = nlog, dc;
    start = 1; step(1); start = 0;
    chk(busy, "R6 busy after start", busy, 1);
    step(10);
    start = 1; step(1); start = 0; // R7 second start while busy
    wait_done(dc);
    chk(dc == 1, "R6 done single pulse", dc, 1);
    chk(nlog - n0 == 4, "R3 R7 frame count", nlog - n0, 4);
    chk(log_q[n0] == {mpl, 2'b00}, "R2 R3 mode frame", log_q[n0], {mpl, 2'b00});
    chk(log_q[n0+1] == {rpl, 2'b01}, "R2 R3 ref frame", log_q[n0+1], {rpl, 2'b01});
    chk(log_q[n0+2] == {vpl, 2'b10}, "R2 R3 vco frame", log_q[n0+2], {vpl, 2'b10});
    chk(log_q[n0+3] == {dpl, 2'b11}, "R2 R3 dco frame", log_q[n0+3], {dpl, 2'b11});
    chk(bits_bad == 0, "R1 bit count", bits_bad, 0);
    chk(stab_bad == 0, "R1 data stable while clock high", stab_bad, 0);
    chk(le_bad == 0, "R4 latch width", le_bad, 0);
    chk(min_gap > 2*HALF, "R5 inter-frame gap", min_gap, 2*HALF + 1);
  endtask

  task automatic t_pins(input bit b0);
    int n0 = nlog;
    txs = 0; step(1);
    chk(perx && !petx, "R9 receive pins", {perx, petx}, 2'b10);
    txs = 1; step(1);
    chk(!perx && petx == b0, "R9 transmit pins", {perx, petx}, {1'b0, b0});
    txs = 0; step(1);
    chk(perx && !petx, "R9 back to receive", {perx, petx}, 2'b10);
    chk(nlog == n0 && !busy && !sclk, "R9 no serial activity", nlog - n0, 0);
  endtask

  task automatic t_update(input logic [1:0] sel, input logic [17:0] pl);
    int n0 = nlog, dc;
    usel = sel; upd = 1; step(1); upd = 0;
    wait_done(dc);
    chk(nlog - n0 == 1, "R8 single frame", nlog - n0, 1);
    chk(log_q[n0] == {pl, sel}, "R8 R2 update frame", log_q[n0], {pl, sel});
  endtask

  task automatic t_upd_sel0();
    int n0 = nlog;
    usel = 2'd0; upd = 1; step(1); upd = 0;
    step(300);
    chk(nlog == n0 && !busy, "R8 select 0 ignored", nlog - n0, 0);
  endtask

  task automatic t_reset_mid();
    int n0;
    start = 1; step(1); start = 0;
    step(100);
    rst_n = 0; #1;
    chk(!sclk && !sle && !busy && !perx && !petx && !sdat, "R10 async reset idle",
        {sclk, sle, busy, perx, petx}, 0);
    step(3); rst_n = 1; step(5);
    n0 = nlog;
    usel = 2'd2; upd = 1; step(1); upd = 0;
    step(300);
    chk(nlog == n0 && !busy, "R10 mode flag cleared", nlog - n0, 0);
    txs = 0; step(2);
    chk(!perx && !petx, "R10 R9 pins idle after reset", {perx, petx}, 0);
  endtask

  initial begin : watchdog
    #1500000;
    n_fail++; n_run++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3); t_reset();
    rst_n = 1; step(5);
    t_reset();
    t_upd_early();
    t_full();
    t_pins(1'b1);
    t_update(2'd2, vpl);
    vpl = 18'h0ABCD; t_update(2'd2, vpl);
    t_update(2'd3, dpl);
    t_upd_sel0();
    mpl = 18'h2A5A4; t_full(); t_pins(1'b0);
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule